// File: doc/BRIEF.md
# Interrupt Acknowledge and Nesting Tracker

This block sits in the per-processor part of an interrupt controller. An arbiter elsewhere chooses the highest-priority pending interrupt and presents its ID and priority. The processor sends an acknowledge request. The block accepts the candidate only if that candidate would preempt the interrupt now in service. On acceptance it returns the ID, asks the arbiter to drop the pending state of that interrupt, and makes the interrupt the new running one. The block does not keep a fixed-depth stack. Each interrupt ID has one link slot, which records the interrupt that was running when this one was taken. The slot also holds the priority of that interrupt.

End-of-interrupt writes can arrive out of order. If the completed ID is the running one, the running ID falls back to its link in one cycle. If it is not, a walker follows the links, one per clock, starting at the running ID. When it finds the entry that points at the completed ID, it splices that entry past it. While the walk runs, the block shows busy and back-pressures both request channels. A legacy mode can ask for a level-triggered interrupt to be made pending again at completion.

Both request channels use valid/ready. A request transfers on a clock edge where valid and ready are both high. The requester must hold valid and its data until that edge. `eoi_ready` is low only while a walk is in progress. `ack_ready` is also low whenever `eoi_valid` is high, so completion wins when both arrive together. The response, pending-clear and re-pend outputs are single-cycle pulses with no back-pressure. They appear one clock after the transfer.

Top module: `nest_ack_ctrl`

## Requirements
- R1: An acknowledge transfer returns ID 1023 and leaves the running ID and running priority unchanged in any of three cases: the candidate ID is 1023, the candidate ID is not below the implemented interrupt count, or the candidate priority is not strictly below the running priority.
- R2: On a successful acknowledge, the response carries the candidate ID. The previous running ID and priority are stored as the link of the candidate. The candidate ID and priority become the running ID and priority.
- R3: The running priority is 9 bits wide and reads 256 (0x100) whenever the running ID is 1023. Otherwise it equals the priority the running interrupt was acknowledged with.
- R4: A successful acknowledge pulses `clr_valid` for one cycle with `clr_id` equal to the acknowledged ID, whatever its trigger type. A refused acknowledge gives no pulse.
- R5: The end-of-interrupt ID is bits [9:0] of `eoi_data`; bits [31:10] are ignored. An ID not below the implemented interrupt count, including 1023, changes nothing and starts no walk.
- R6: An end-of-interrupt is ignored while the running ID is 1023.
- R7: Completing the running ID replaces the running ID and priority with its link, visible one clock after the transfer, with no busy cycle.
- R8: Completing any other in-range ID walks the chain from the running ID. The first entry whose link equals the completed ID takes over the completed ID's link and link priority. If a link of 1023 is reached first, nothing changes. The running ID and priority do not change during a walk.
- R9: When `legacy_mode` is 1 and a completion is accepted (R5, R6), `repend_valid` pulses with `repend_id` equal to the completed ID if that ID's line is high, enabled, targeted here, and its edge-configuration bit is 0 (level). Otherwise it does not pulse. It never pulses when `legacy_mode` is 0.
- R10: A walk reads one link per clock. `busy` is high for exactly as many cycles as links read: one per entry visited up to and including the matching or terminating link. Both ready outputs are low while busy.
- R11: When `ack_valid` and `eoi_valid` are both high, the completion transfers first and the acknowledge waits with `ack_ready` low.
- R12: After reset, the running ID is 1023, the running priority is 256, every link is 1023, `busy` is 0, both ready outputs are 1, and no pulse output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| legacy_mode | input | 1 | Enables re-pending of level interrupts at completion |
| pend_id | input | 10 | Highest pending ID from the arbiter (1023 = none) |
| pend_prio | input | 8 | Priority of `pend_id`, lower is more urgent |
| ack_valid | input | 1 | Acknowledge request |
| ack_ready | output | 1 | Acknowledge can transfer |
| ack_rsp_valid | output | 1 | Acknowledge response pulse |
| ack_rsp_id | output | 10 | Acknowledged ID or 1023 |
| eoi_valid | input | 1 | End-of-interrupt request |
| eoi_ready | output | 1 | End-of-interrupt can transfer |
| eoi_data | input | 32 | Written completion value, ID in bits [9:0] |
| line_high | input | NUM_IRQ | Current input level per interrupt |
| irq_enabled | input | NUM_IRQ | Enable per interrupt |
| edge_cfg | input | NUM_IRQ | 1 = edge-triggered, 0 = level |
| to_this_cpu | input | NUM_IRQ | Interrupt is targeted at this processor |
| clr_valid | output | 1 | Pending-clear request pulse |
| clr_id | output | 10 | ID whose pending state is to be cleared |
| repend_valid | output | 1 | Re-pend request pulse |
| repend_id | output | 10 | ID to be made pending again |
| run_id | output | 10 | Running interrupt ID (1023 = none) |
| run_prio | output | 9 | Running priority (256 = none) |
| busy | output | 1 | Chain walk in progress |

## Verification
The acknowledge and the completion can collide in one cycle. The bench provokes this by raising both valids on the same falling edge while one interrupt is running and a preempting candidate is waiting. The candidate is judged correct only if three things hold: `ack_ready` is low before the edge, the first edge pops the running interrupt with no response pulse, and the next edge grants the candidate against the restored idle priority. A second overlap occurs when a stalled acknowledge meets an ongoing walk. The bench checks this by counting busy cycles against a link count it derives itself, with the ready outputs held low throughout.

// File: rtl/nac_pkg.sv
package nac_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NO_IRQ = 10'd1023;
  typedef enum logic {WK_IDLE, WK_SCAN} wk_state_e;
endpackage

// File: rtl/nac_ack_gate.sv
module nac_ack_gate
  import nac_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 8
) (
  input  logic [ID_W-1:0]   pend_id,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W:0]   run_prio,
  output logic              take
);
  logic id_real;
  logic preempts;

  // A candidate is real only if it names an implemented interrupt.
  assign id_real  = (pend_id != NO_IRQ) && (pend_id < ID_W'(NUM_IRQ));
  // It must be strictly more urgent than what is already in service.
  assign preempts = {1'b0, pend_prio} < run_prio;
  assign take     = id_real && preempts;
endmodule

// File: rtl/nac_eoi_decode.sv
module nac_eoi_decode
  import nac_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic [31:0]        eoi_data,
  input  logic [ID_W-1:0]    run_id,
  input  logic               legacy_mode,
  input  logic [NUM_IRQ-1:0] line_high,
  input  logic [NUM_IRQ-1:0] irq_enabled,
  input  logic [NUM_IRQ-1:0] edge_cfg,
  input  logic [NUM_IRQ-1:0] to_this_cpu,
  output logic [ID_W-1:0]    eoi_id,
  output logic               act,
  output logic               is_top,
  output logic               repend
);
  localparam int ADDR_W = $clog2(NUM_IRQ);

  logic [ADDR_W-1:0] idx;
  logic              unused_hi;

  assign eoi_id    = eoi_data[ID_W-1:0];
  assign unused_hi = ^eoi_data[31:ID_W];
  assign idx       = eoi_id[ADDR_W-1:0];

  // Out-of-range IDs (1023 included) and an empty chain make the write a no-op.
  assign act    = (eoi_id < ID_W'(NUM_IRQ)) && (run_id != NO_IRQ);
  assign is_top = act && (eoi_id == run_id);
  assign repend = act && legacy_mode && !edge_cfg[idx] && irq_enabled[idx]
                  && line_high[idx] && to_this_cpu[idx];
endmodule

// File: rtl/nac_link_store.sv
module nac_link_store
  import nac_pkg::*;
#(
  parameter int NUM_IRQ  = 32,
  parameter int PRIO_W   = 8,
  parameter int RD_PORTS = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we,
  input  logic [$clog2(NUM_IRQ)-1:0]          waddr,
  input  logic [ID_W-1:0]                     wlink,
  input  logic [PRIO_W:0]                     wprio,
  input  logic [RD_PORTS-1:0][$clog2(NUM_IRQ)-1:0] raddr,
  output logic [RD_PORTS-1:0][ID_W-1:0]       rlink,
  output logic [RD_PORTS-1:0][PRIO_W:0]       rprio
);
  localparam int ADDR_W = $clog2(NUM_IRQ);
  localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  logic [ID_W-1:0] link_q [NUM_IRQ];
  logic [PRIO_W:0] prio_q [NUM_IRQ];

  // One slot per interrupt: who was running before it, and at what priority.
  for (genvar e = 0; e < NUM_IRQ; e++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        link_q[e] <= NO_IRQ;
        prio_q[e] <= IDLE_PRIO;
      end else if (we && (waddr == ADDR_W'(e))) begin
        link_q[e] <= wlink;
        prio_q[e] <= wprio;
      end
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rlink[p] = link_q[raddr[p]];
    assign rprio[p] = prio_q[raddr[p]];
  end
endmodule

// File: rtl/nac_chain_walker.sv
module nac_chain_walker
  import nac_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [$clog2(NUM_IRQ)-1:0] start_id,
  input  logic [ID_W-1:0]            target_id,
  output logic [$clog2(NUM_IRQ)-1:0] cur_addr,
  input  logic [ID_W-1:0]            cur_link,
  output logic [$clog2(NUM_IRQ)-1:0] tgt_addr,
  input  logic [ID_W-1:0]            tgt_link,
  input  logic [PRIO_W:0]            tgt_prio,
  output logic                       fix_we,
  output logic [$clog2(NUM_IRQ)-1:0] fix_addr,
  output logic [ID_W-1:0]            fix_link,
  output logic [PRIO_W:0]            fix_prio,
  output logic                       busy
);
  localparam int ADDR_W = $clog2(NUM_IRQ);
  localparam int STEP_W = $clog2(NUM_IRQ + 1);

  wk_state_e         state_q;
  logic [ADDR_W-1:0] cur_q;
  logic [ID_W-1:0]   tgt_q;
  logic [STEP_W-1:0] steps_q;
  logic              at_end, found, give_up;

  assign cur_addr = cur_q;
  assign tgt_addr = tgt_q[ADDR_W-1:0];
  assign busy     = (state_q == WK_SCAN);

  assign at_end  = (cur_link == NO_IRQ);
  assign found   = !at_end && (cur_link == tgt_q);
  // A corrupted chain cannot be longer than the number of slots.
  assign give_up = (steps_q == STEP_W'(NUM_IRQ - 1));

  // Splice: the entry pointing at the target inherits the target's link.
  assign fix_we   = busy && found;
  assign fix_addr = cur_q;
  assign fix_link = tgt_link;
  assign fix_prio = tgt_prio;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      cur_q   <= '0;
      tgt_q   <= NO_IRQ;
      steps_q <= '0;
    end else begin
      unique case (state_q)
        WK_IDLE: begin
          if (start) begin
            state_q <= WK_SCAN;
            cur_q   <= start_id;
            tgt_q   <= target_id;
            steps_q <= '0;
          end
        end
        WK_SCAN: begin
          if (at_end || found || give_up) begin
            state_q <= WK_IDLE;
          end else begin
            cur_q   <= cur_link[ADDR_W-1:0];
            steps_q <= steps_q + 1'b1;
          end
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start); // R10
  AST_WALK_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R10
endmodule

// File: rtl/nest_ack_ctrl.sv
module nest_ack_ctrl
  import nac_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               legacy_mode,
  input  logic [9:0]         pend_id,
  input  logic [PRIO_W-1:0]  pend_prio,
  input  logic               ack_valid,
  output logic               ack_ready,
  output logic               ack_rsp_valid,
  output logic [9:0]         ack_rsp_id,
  input  logic               eoi_valid,
  output logic               eoi_ready,
  input  logic [31:0]        eoi_data,
  input  logic [NUM_IRQ-1:0] line_high,
  input  logic [NUM_IRQ-1:0] irq_enabled,
  input  logic [NUM_IRQ-1:0] edge_cfg,
  input  logic [NUM_IRQ-1:0] to_this_cpu,
  output logic               clr_valid,
  output logic [9:0]         clr_id,
  output logic               repend_valid,
  output logic [9:0]         repend_id,
  output logic [9:0]         run_id,
  output logic [PRIO_W:0]    run_prio,
  output logic               busy
);
  localparam int ADDR_W = $clog2(NUM_IRQ);
  localparam int RD_N   = 3;
  localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  logic [ID_W-1:0]   run_id_q;
  logic [PRIO_W:0]   run_prio_q;
  logic              rsp_v_q, clr_v_q, rep_v_q;
  logic [ID_W-1:0]   rsp_id_q, clr_id_q, rep_id_q;

  logic              ack_take, ack_fire, eoi_fire;
  logic [ID_W-1:0]   eoi_id;
  logic              eoi_act, eoi_top, eoi_rep;
  logic              walk_busy, walk_start;

  logic                        st_we;
  logic [ADDR_W-1:0]           st_waddr;
  logic [ID_W-1:0]             st_wlink;
  logic [PRIO_W:0]             st_wprio;
  logic [RD_N-1:0][ADDR_W-1:0] st_raddr;
  logic [RD_N-1:0][ID_W-1:0]   st_rlink;
  logic [RD_N-1:0][PRIO_W:0]   st_rprio;

  logic              fix_we;
  logic [ADDR_W-1:0] fix_addr, cur_addr, tgt_addr;
  logic [ID_W-1:0]   fix_link;
  logic [PRIO_W:0]   fix_prio;

  // Completion has precedence; a walk stalls both channels.
  assign eoi_ready = !walk_busy;
  assign ack_ready = !walk_busy && !eoi_valid;
  assign ack_fire  = ack_valid && ack_ready;
  assign eoi_fire  = eoi_valid && eoi_ready;

  nac_ack_gate #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_gate (
    .pend_id  (pend_id),
    .pend_prio(pend_prio),
    .run_prio (run_prio_q),
    .take     (ack_take)
  );

  nac_eoi_decode #(.NUM_IRQ(NUM_IRQ)) u_eoi (
    .eoi_data   (eoi_data),
    .run_id     (run_id_q),
    .legacy_mode(legacy_mode),
    .line_high  (line_high),
    .irq_enabled(irq_enabled),
    .edge_cfg   (edge_cfg),
    .to_this_cpu(to_this_cpu),
    .eoi_id     (eoi_id),
    .act        (eoi_act),
    .is_top     (eoi_top),
    .repend     (eoi_rep)
  );

  // Acknowledge pushes and the walker's splice never share a cycle.
  assign st_we    = (ack_fire && ack_take) || fix_we;
  assign st_waddr = fix_we ? fix_addr : pend_id[ADDR_W-1:0];
  assign st_wlink = fix_we ? fix_link : run_id_q;
  assign st_wprio = fix_we ? fix_prio : run_prio_q;
  assign st_raddr = {tgt_addr, cur_addr, eoi_id[ADDR_W-1:0]};

  nac_link_store #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .RD_PORTS(RD_N)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (st_we),
    .waddr(st_waddr),
    .wlink(st_wlink),
    .wprio(st_wprio),
    .raddr(st_raddr),
    .rlink(st_rlink),
    .rprio(st_rprio)
  );

  assign walk_start = eoi_fire && eoi_act && !eoi_top;

  nac_chain_walker #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (walk_start),
    .start_id (run_id_q[ADDR_W-1:0]),
    .target_id(eoi_id),
    .cur_addr (cur_addr),
    .cur_link (st_rlink[1]),
    .tgt_addr (tgt_addr),
    .tgt_link (st_rlink[2]),
    .tgt_prio (st_rprio[2]),
    .fix_we   (fix_we),
    .fix_addr (fix_addr),
    .fix_link (fix_link),
    .fix_prio (fix_prio),
    .busy     (walk_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_id_q   <= NO_IRQ;
      run_prio_q <= IDLE_PRIO;
      rsp_v_q    <= 1'b0;
      rsp_id_q   <= NO_IRQ;
      clr_v_q    <= 1'b0;
      clr_id_q   <= NO_IRQ;
      rep_v_q    <= 1'b0;
      rep_id_q   <= NO_IRQ;
    end else begin
      rsp_v_q <= 1'b0;
      clr_v_q <= 1'b0;
      rep_v_q <= 1'b0;
      if (ack_fire) begin
        rsp_v_q  <= 1'b1;
        rsp_id_q <= ack_take ? pend_id : NO_IRQ;
        if (ack_take) begin
          run_id_q   <= pend_id;
          run_prio_q <= {1'b0, pend_prio};
          clr_v_q    <= 1'b1;
          clr_id_q   <= pend_id;
        end
      end
      if (eoi_fire && eoi_act) begin
        if (eoi_rep) begin
          rep_v_q  <= 1'b1;
          rep_id_q <= eoi_id;
        end
        if (eoi_top) begin
          run_id_q   <= st_rlink[0];
          run_prio_q <= st_rprio[0];
        end
      end
    end
  end

  assign ack_rsp_valid = rsp_v_q;
  assign ack_rsp_id    = rsp_id_q;
  assign clr_valid     = clr_v_q;
  assign clr_id        = clr_id_q;
  assign repend_valid  = rep_v_q;
  assign repend_id     = rep_id_q;
  assign run_id        = run_id_q;
  assign run_prio      = run_prio_q;
  assign busy          = walk_busy;

  AST_REFUSE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire && !ack_take |=> ack_rsp_id == NO_IRQ && $stable(run_id_q)); // R1
  AST_ACK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire && ack_take |=> run_id_q == $past(pend_id) && clr_v_q && clr_id_q == $past(pend_id)); // R2
  AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    run_id_q == NO_IRQ |-> run_prio_q == IDLE_PRIO); // R3
  AST_PRIO_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire && ack_take |=> run_prio_q < $past(run_prio_q)); // R3
  AST_EOI_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire && eoi_data[9:0] >= 10'(NUM_IRQ) |=> $stable(run_id_q) && !walk_busy); // R5
  AST_EOI_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire && run_id_q == NO_IRQ |=> run_id_q == NO_IRQ && !rep_v_q); // R6
  AST_WALK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    walk_busy |=> $stable(run_id_q) && $stable(run_prio_q)); // R8
endmodule

// File: tb/nest_ack_ctrl_test.sv
module nest_ack_ctrl_test;
  localparam int N = 32;

  logic clk = 0, rst_n = 0;
  logic legacy_mode = 0;
  logic [9:0] pend_id = 10'd1023;
  logic [7:0] pend_prio = 0;
  logic ack_valid = 0, eoi_valid = 0;
  logic [31:0] eoi_data = 0;
  logic [N-1:0] line_high = 0, irq_enabled = 0, edge_cfg = 0, to_this_cpu = 0;
  logic ack_ready, ack_rsp_valid, eoi_ready, clr_valid, repend_valid, busy;
  logic [9:0] ack_rsp_id, clr_id, repend_id, run_id;
  logic [8:0] run_prio;

  int errors = 0, checks = 0;
  bit done = 0;
  int m_link [N];
  int m_lprio [N];
  int m_run = 1023, m_rprio = 256;

  always #10 clk = ~clk;

  nest_ack_ctrl #(.NUM_IRQ(N), .PRIO_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
    .pend_id(pend_id), .pend_prio(pend_prio),
    .ack_valid(ack_valid), .ack_ready(ack_ready),
    .ack_rsp_valid(ack_rsp_valid), .ack_rsp_id(ack_rsp_id),
    .eoi_valid(eoi_valid), .eoi_ready(eoi_ready), .eoi_data(eoi_data),
    .line_high(line_high), .irq_enabled(irq_enabled), .edge_cfg(edge_cfg),
    .to_this_cpu(to_this_cpu), .clr_valid(clr_valid), .clr_id(clr_id),
    .repend_valid(repend_valid), .repend_id(repend_id),
    .run_id(run_id), .run_prio(run_prio), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic chk_run(input string req);
    chk(run_id == 10'(m_run), req, int'(run_id), m_run);
    chk(run_prio == 9'(m_rprio), req, int'(run_prio), m_rprio);
  endtask

  task automatic model_pop();
    int id = m_run;
    m_run = m_link[id];
    m_rprio = m_lprio[id];
  endtask

  task automatic do_ack(input int id, input int prio);
    bit hit;
    @(negedge clk);
    pend_id = 10'(id); pend_prio = 8'(prio); ack_valid = 1;
    #1 chk(ack_ready == 1, "R10", int'(ack_ready), 1);
    hit = (id != 1023) && (id < N) && (prio < m_rprio);
    @(posedge clk);
    @(negedge clk);
    ack_valid = 0;
    chk(ack_rsp_valid == 1, "R1", int'(ack_rsp_valid), 1);
    chk(ack_rsp_id == 10'(hit ? id : 1023), hit ? "R2" : "R1", int'(ack_rsp_id), hit ? id : 1023);
    chk(clr_valid == hit, "R4", int'(clr_valid), int'(hit));
    if (hit) begin
      chk(clr_id == 10'(id), "R4", int'(clr_id), id);
      m_link[id] = m_run; m_lprio[id] = m_rprio;
      m_run = id; m_rprio = prio;
    end
    chk_run(hit ? "R2" : "R1");
  endtask

  task automatic do_eoi(input logic [31:0] data);
    int id = int'(data[9:0]);
    bit act = (id < N) && (m_run != 1023);
    bit rep = act && legacy_mode && !edge_cfg[id % N] && irq_enabled[id % N]
              && line_high[id % N] && to_this_cpu[id % N];
    int steps = 0, seen = 0;
    @(negedge clk);
    eoi_data = data; eoi_valid = 1;
    #1 chk(eoi_ready == 1 && ack_ready == 0, "R11", int'(eoi_ready), 1);
    @(posedge clk);
    @(negedge clk);
    eoi_valid = 0;
    chk(repend_valid == rep, "R9", int'(repend_valid), int'(rep));
    if (rep) chk(repend_id == 10'(id), "R9", int'(repend_id), id);
    if (act && id == m_run) begin
      model_pop();
      chk(busy == 0, "R7", int'(busy), 0);
    end else if (act) begin
      int t = m_run;
      forever begin
        int nx = m_link[t];
        steps++;
        if (nx == 1023) break;
        if (nx == id) begin
          m_link[t] = m_link[id]; m_lprio[t] = m_lprio[id];
          break;
        end
        t = nx;
      end
      chk_run("R8");
    end
    while (busy) begin
      seen++;
      #1 chk(ack_ready == 0 && eoi_ready == 0, "R10", int'(ack_ready), 0);
      @(negedge clk);
    end
    chk(seen == steps, "R10", seen, steps);
    chk_run(!act ? ((id >= N) ? "R5" : "R6") : (steps == 0 ? "R7" : "R8"));
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_link[i] = 1023; m_lprio[i] = 256; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(run_id == 10'd1023, "R12", int'(run_id), 1023);
    chk(run_prio == 9'd256, "R12", int'(run_prio), 256);
    chk(busy == 0 && ack_ready == 1 && eoi_ready == 1, "R12", int'(busy), 0);
    chk(!ack_rsp_valid && !clr_valid && !repend_valid, "R12", int'(clr_valid), 0);

    // R6: completion with nothing running
    do_eoi(32'd3);
    // R1: no candidate, out-of-range candidate
    do_ack(1023, 0);
    do_ack(40, 0);

    // R2/R3: build an eight-deep chain of falling priorities
    for (int d = 0; d < 8; d++) do_ack(2 + 3 * d, 200 - 20 * d);
    do_ack(30, m_rprio);      // R1 equal priority refused
    do_ack(30, m_rprio + 1);  // R1 less urgent refused

    // R5: ignored IDs, then a masked completion of the running ID
    do_eoi(32'hFFFF_FFFF);
    do_eoi(32'd35);
    do_eoi(32'hABCD_FC00 | 32'(m_run));  // R7 pop through high junk
    // R8: out-of-order removals, and a miss
    do_eoi(32'd8);
    do_eoi(32'd31);
    do_eoi(32'd2);
    // Pop the remainder, each pop exposing the spliced links
    while (m_run != 1023) do_eoi(32'(m_run));

    // R8 stress: permuted completion order over a fresh chain
    for (int d = 0; d < 8; d++) do_ack(1 + 4 * d, 150 - 10 * d);
    for (int k = 0; k < 8; k++) do_eoi(32'(1 + 4 * ((k * 5) % 8)));
    chk_run("R8");

    // R1/R3 priority sweep against a running priority of 100
    do_ack(7, 100);
    for (int p = 0; p < 256; p++) begin
      do_ack(9, p);
      if (p < 100) do_eoi(32'd9);
    end
    do_eoi(32'd7);

    // R9: every combination of the four conditions, legacy on
    legacy_mode = 1;
    for (int c = 0; c < 16; c++) begin
      line_high[5] = c[0]; irq_enabled[5] = c[1];
      edge_cfg[5] = ~c[2]; to_this_cpu[5] = c[3];
      do_ack(5, 10);
      do_eoi(32'd5);
    end
    do_eoi(32'd5);  // R6 with all conditions true: no re-pend
    legacy_mode = 0;
    do_ack(5, 10);
    do_eoi(32'd5);  // R9 legacy off

    // R11: simultaneous acknowledge and completion
    do_ack(4, 50);
    @(negedge clk);
    pend_id = 10'd6; pend_prio = 8'd20; ack_valid = 1;
    eoi_data = 32'd4; eoi_valid = 1;
    #1 chk(ack_ready == 0, "R11", int'(ack_ready), 0);
    @(posedge clk);
    @(negedge clk);
    eoi_valid = 0;
    model_pop();
    chk(ack_rsp_valid == 0, "R11", int'(ack_rsp_valid), 0);
    chk_run("R11");
    @(posedge clk);
    @(negedge clk);
    ack_valid = 0;
    chk(ack_rsp_valid == 1 && ack_rsp_id == 10'd6, "R11", int'(ack_rsp_id), 6);
    m_link[6] = m_run; m_lprio[6] = m_rprio; m_run = 6; m_rprio = 20;
    chk_run("R11");
    do_eoi(32'd6);
    chk_run("R3");

    finish_run();
  end
endmodule